// File: doc/BRIEF.md
# A/D Scan Sequencer with Tagged Sample FIFO

This block steps a multiplexed 12-bit A/D converter through a programmed ring of input channels and collects the results in a sample FIFO. Host software programs a scan window (first and last channel), a per-channel range code and a control word. It then starts conversions by software write, by an internal pacer tick or by an external trigger edge. For each conversion the block drives a start pulse, the channel number and that channel's range code to an external converter. It waits for the converter's done strobe, then stores the 12-bit result together with a 4-bit channel tag.

A channel whose range code marks it differential consumes two adjacent inputs, so the scan skips the channel after it. The host drains the FIFO through a show-ahead pop port and watches a status word. An interrupt output fires either on every stored sample or when the FIFO crosses half full.

Top module: `adc_scan_seq`

## Requirements
- R1: A write to the scan-window register (address 2) loads the first channel from bits 3:0 and the last channel from bits 11:8, and makes the first channel current. After each completed conversion the current channel advances; from the last channel it returns to the first, and channel numbers wrap modulo 16, so a first channel above the last scans through 15 and 0.
- R2: Each stored FIFO word holds the converted channel in bits 15:12 and the 12-bit converter result in bits 11:0.
- R3: A channel whose range code has bit 5 set is differential. After it the scan moves two channels ahead, except that it returns to the first channel when the skipped channel is the last one.
- R4: A write to the range register (address 1) stores bits 5:0 as the range code of the current channel. While a conversion is in progress, conv_chan_o and conv_range_o show its channel and that channel's stored code.
- R5: A conversion starts on one of three sources, each enabled by a control bit. A write to address 0 starts one when bit 0 is set. A pacer tick starts one when bit 1 is set; while bit 3 is also set, the tick counts only with ext_gate_i high. A rising edge on ext_trig_i starts one when bit 2 is set. A trigger whose source is disabled starts nothing.
- R6: status_o bits 6:0 echo the control register (address 3). Bit 8 is FIFO empty, bit 9 is half full (at least half the depth), bit 10 is the full flag and bit 11 is the pending interrupt. All other bits read 0. After reset status_o is 0x0100.
- R7: The full flag sets when the FIFO reaches its depth. A result arriving while the FIFO is full is discarded. The full flag stays set, even after pops, until the FIFO is cleared.
- R8: A write of any value to address 5 empties the FIFO and drops the full flag.
- R9: With interrupts enabled (control bit 4) and control bit 5 clear, every stored sample sets irq_o. A write to address 4 clears it. With bit 4 clear, irq_o never sets.
- R10: With control bits 4 and 5 set, irq_o sets when the half-full condition rises, and not on the stores before it.
- R11: A pop in the same cycle as a store leaves the occupancy unchanged. The popped word leaves, and the new word is kept.
- R12: When an interrupt-clear write and an interrupt-setting store fall in the same cycle, irq_o ends set.
- R13: While a conversion is in progress, further triggers are dropped and the current channel holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| fifo_pop_i | input | 1 | Pop the FIFO head |
| fifo_data_o | output | 16 | FIFO head word (0 when empty) |
| status_o | output | 16 | Status word |
| pacer_tick_i | input | 1 | Internal pacer tick |
| ext_trig_i | input | 1 | External trigger level (rising edge starts) |
| ext_gate_i | input | 1 | External gate for pacer ticks |
| conv_start_o | output | 1 | One-cycle converter start pulse |
| conv_chan_o | output | 4 | Channel being converted |
| conv_range_o | output | 6 | Range code of that channel |
| conv_done_i | input | 1 | Converter done strobe |
| conv_data_i | input | 12 | Converter result |
| irq_o | output | 1 | Interrupt request |

## Verification
The FIFO store from a converter done strobe can fall in the same cycle as a host pop, and in the same cycle as an interrupt-clear write. The bench raises conv_done_i on the very clock edge that it asserts fifo_pop_i or the clear write. It then judges the pop case at the ports: the new word must be at the head and one further pop must empty the FIFO. It judges the clear case by irq_o remaining high afterwards. A full-FIFO store followed by pops is used to show that the full flag outlives the pops.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam logic [2:0] ADDR_TRIG   = 3'd0;
  localparam logic [2:0] ADDR_RANGE  = 3'd1;
  localparam logic [2:0] ADDR_MUX    = 3'd2;
  localparam logic [2:0] ADDR_CTRL   = 3'd3;
  localparam logic [2:0] ADDR_CLRINT = 3'd4;
  localparam logic [2:0] ADDR_CLRFF  = 3'd5;

  localparam int CB_SW      = 0;
  localparam int CB_PACER   = 1;
  localparam int CB_EXT     = 2;
  localparam int CB_GATE    = 3;
  localparam int CB_IEN     = 4;
  localparam int CB_HALFIRQ = 5;
  localparam int CTRL_W     = 7;

  localparam int TAG_W    = 4;
  localparam int DIFF_BIT = 5;
endpackage

// File: rtl/adc_scan_chan.sv
module adc_scan_chan #(
  parameter int N_CH     = 16,
  parameter int RANGE_W  = 6,
  parameter int DIFF_BIT = 5,
  localparam int CH_W    = $clog2(N_CH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mux_we_i,
  input  logic [CH_W-1:0]    first_i,
  input  logic [CH_W-1:0]    last_i,
  input  logic               range_we_i,
  input  logic [RANGE_W-1:0] range_i,
  input  logic               trig_i,
  input  logic               done_i,
  output logic               start_o,
  output logic               store_o,
  output logic [CH_W-1:0]    chan_o,
  output logic [RANGE_W-1:0] range_o
);
  logic [RANGE_W-1:0] tbl_q [N_CH];
  logic [CH_W-1:0]    first_q, last_q, cur_q, step1, nxt;
  logic               busy_q, start_q, diff;

  assign diff  = tbl_q[cur_q][DIFF_BIT];
  assign step1 = cur_q + CH_W'(1);

  // differential entry consumes the pair; wrap to first on reaching last
  always_comb begin
    if (cur_q == last_q || (diff && step1 == last_q)) nxt = first_q;
    else if (diff)                                     nxt = cur_q + CH_W'(2);
    else                                               nxt = step1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= '0;
      last_q  <= '0;
      cur_q   <= '0;
    end else if (mux_we_i) begin
      first_q <= first_i;
      last_q  <= last_i;
      cur_q   <= first_i;
    end else if (busy_q && done_i) begin
      cur_q   <= nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_CH; i++) tbl_q[i] <= '0;
    end else if (range_we_i) begin
      tbl_q[cur_q] <= range_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= trig_i && !busy_q;
      if (trig_i && !busy_q) busy_q <= 1'b1;
      else if (done_i)       busy_q <= 1'b0;
    end
  end

  assign start_o = start_q;
  assign store_o = busy_q && done_i;
  assign chan_o  = cur_q;
  assign range_o = tbl_q[cur_q];

  AST_WRAP_TO_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && done_i && !mux_we_i && cur_q == last_q |=> cur_q == first_q); // R1
  AST_DIFF_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && done_i && !mux_we_i && diff && cur_q != last_q && step1 != last_q
    |=> cur_q == $past(cur_q) + CH_W'(2)); // R3
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_i && !mux_we_i |=> $stable(cur_q) && !start_o); // R13
endmodule

// File: rtl/adc_scan_fifo.sv
module adc_scan_fifo #(
  parameter int DEPTH = 1024,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         half_o,
  output logic         full_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          full_q, push_ok, pop_ok;

  assign push_ok = push_i && cnt_q != FULL_CNT && !clr_i;
  assign pop_ok  = pop_i && cnt_q != '0 && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      full_q   <= 1'b0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      full_q   <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + AW'(1);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + CW'(1);
      else if (pop_ok && !push_ok) cnt_q <= cnt_q - CW'(1);
      // sticky: only a clear drops it
      if ((push_i && cnt_q == FULL_CNT) ||
          (push_ok && !pop_ok && cnt_q == FULL_CNT - CW'(1)))
        full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = (cnt_q == '0) ? '0 : mem[rd_ptr_q];
  assign empty_o = cnt_q == '0;
  assign half_o  = cnt_q >= HALF_CNT;
  assign full_o  = full_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT); // R7
  AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && !clr_i |=> full_q); // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0 && !full_q); // R8
  AST_POP_PUSH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && !clr_i && cnt_q != '0 && cnt_q != FULL_CNT |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/adc_scan_irq.sv
module adc_scan_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ien_i,
  input  logic half_mode_i,
  input  logic store_i,
  input  logic half_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q, half_d_q, set;

  assign set = ien_i && (half_mode_i ? (half_i && !half_d_q) : store_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q    <= 1'b0;
      half_d_q <= 1'b0;
    end else begin
      half_d_q <= half_i;
      if (set)        irq_q <= 1'b1;  // a new event outranks the clear
      else if (clr_i) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_i && !irq_q |=> !irq_q); // R9
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_i && !half_mode_i && store_i && clr_i |=> irq_q); // R12
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int FIFO_DEPTH = 1024,
  parameter int N_CH       = 16,
  parameter int RES_W      = 12,
  parameter int RANGE_W    = 6,
  localparam int CH_W      = $clog2(N_CH),
  localparam int WORD_W    = TAG_W + RES_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [15:0]        reg_wdata_i,
  input  logic               fifo_pop_i,
  output logic [WORD_W-1:0]  fifo_data_o,
  output logic [15:0]        status_o,
  input  logic               pacer_tick_i,
  input  logic               ext_trig_i,
  input  logic               ext_gate_i,
  output logic               conv_start_o,
  output logic [CH_W-1:0]    conv_chan_o,
  output logic [RANGE_W-1:0] conv_range_o,
  input  logic               conv_done_i,
  input  logic [RES_W-1:0]   conv_data_i,
  output logic               irq_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              ext_q, trig, store;
  logic              we_trig, we_range, we_mux, we_ctrl, we_clrint, we_clrff;
  logic              ff_empty, ff_half, ff_full;

  assign we_trig   = reg_we_i && reg_addr_i == ADDR_TRIG;
  assign we_range  = reg_we_i && reg_addr_i == ADDR_RANGE;
  assign we_mux    = reg_we_i && reg_addr_i == ADDR_MUX;
  assign we_ctrl   = reg_we_i && reg_addr_i == ADDR_CTRL;
  assign we_clrint = reg_we_i && reg_addr_i == ADDR_CLRINT;
  assign we_clrff  = reg_we_i && reg_addr_i == ADDR_CLRFF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ext_q  <= 1'b0;
    end else begin
      ext_q <= ext_trig_i;
      if (we_ctrl) ctrl_q <= reg_wdata_i[CTRL_W-1:0];
    end
  end

  assign trig = (we_trig && ctrl_q[CB_SW])
              || (pacer_tick_i && ctrl_q[CB_PACER] && (!ctrl_q[CB_GATE] || ext_gate_i))
              || (ext_trig_i && !ext_q && ctrl_q[CB_EXT]);

  adc_scan_chan #(.N_CH(N_CH), .RANGE_W(RANGE_W), .DIFF_BIT(DIFF_BIT)) chan_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mux_we_i  (we_mux),
    .first_i   (reg_wdata_i[CH_W-1:0]),
    .last_i    (reg_wdata_i[8 +: CH_W]),
    .range_we_i(we_range),
    .range_i   (reg_wdata_i[RANGE_W-1:0]),
    .trig_i    (trig),
    .done_i    (conv_done_i),
    .start_o   (conv_start_o),
    .store_o   (store),
    .chan_o    (conv_chan_o),
    .range_o   (conv_range_o)
  );

  adc_scan_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) fifo_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (we_clrff),
    .push_i (store),
    .wdata_i({TAG_W'(conv_chan_o), conv_data_i}),
    .pop_i  (fifo_pop_i),
    .rdata_o(fifo_data_o),
    .empty_o(ff_empty),
    .half_o (ff_half),
    .full_o (ff_full)
  );

  adc_scan_irq irq_ctl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ien_i      (ctrl_q[CB_IEN]),
    .half_mode_i(ctrl_q[CB_HALFIRQ]),
    .store_i    (store),
    .half_i     (ff_half),
    .clr_i      (we_clrint),
    .irq_o      (irq_o)
  );

  assign status_o = {4'b0, irq_o, ff_full, ff_half, ff_empty, 1'b0, ctrl_q};

  AST_NO_TRIG_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q[CB_PACER:CB_SW] == 2'b00 && !ctrl_q[CB_EXT] && !we_ctrl |=> !conv_start_o); // R5
endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
  localparam int DEPTH = 16;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, fifo_pop_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0, fifo_data_o, status_o;
  logic        pacer_tick_i = 1'b0, ext_trig_i = 1'b0, ext_gate_i = 1'b0;
  logic        conv_start_o, conv_done_i = 1'b0, irq_o;
  logic [3:0]  conv_chan_o;
  logic [5:0]  conv_range_o;
  logic [11:0] conv_data_i = '0;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  adc_scan_seq #(.FIFO_DEPTH(DEPTH)) dut_i (.*);

  // {chan[21:18], range[17:12], data[11:0]}; window 3..6, ch4 differential
  localparam logic [21:0] VEC [8] = '{
    {4'd3, 6'h01, 12'h0A5}, {4'd4, 6'h21, 12'h5A0}, {4'd6, 6'h13, 12'hFFF},
    {4'd3, 6'h01, 12'h000}, {4'd4, 6'h21, 12'h123}, {4'd6, 6'h13, 12'h800},
    {4'd3, 6'h01, 12'h7FF}, {4'd4, 6'h21, 12'h456}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic wait_start(input string req, input logic [3:0] ech, input logic [5:0] erg);
    bit seen = 1'b0;
    for (int k = 0; k < 10 && !seen; k++) begin
      if (conv_start_o) seen = 1'b1; else @(negedge clk_i);
    end
    chk(seen, req, 32'(seen), 32'd1);
    chk(conv_chan_o == ech && conv_range_o == erg, req,
        {22'd0, conv_chan_o, conv_range_o}, {22'd0, ech, erg});
  endtask

  task automatic no_start(input string req);
    bit seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (conv_start_o) seen = 1'b1;
      @(negedge clk_i);
    end
    chk(!seen, req, 32'(seen), 32'd0);
  endtask

  task automatic done(input logic [11:0] d, input bit pop, input bit clrint);
    @(negedge clk_i);
    conv_done_i = 1'b1; conv_data_i = d; fifo_pop_i = pop;
    if (clrint) begin reg_we_i = 1'b1; reg_addr_i = 3'd4; end
    @(negedge clk_i);
    conv_done_i = 1'b0; fifo_pop_i = 1'b0; reg_we_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic sw_conv(input string req, input logic [3:0] ch, input logic [5:0] rg, input logic [11:0] d);
    wr(3'd0, 16'h0);
    wait_start(req, ch, rg);
    done(d, 1'b0, 1'b0);
  endtask

  task automatic pop_chk(input string req, input logic [15:0] exp);
    chk(fifo_data_o == exp, req, 32'(fifo_data_o), 32'(exp));
    @(negedge clk_i); fifo_pop_i = 1'b1;
    @(negedge clk_i); fifo_pop_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(status_o == 16'h0100 && !irq_o && !conv_start_o, "R6 reset", 32'(status_o), 32'h0100);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4: select single channel, load its range code
    wr(3'd2, 16'h0303); wr(3'd1, 16'h0001);
    wr(3'd2, 16'h0404); wr(3'd1, 16'h0021);
    wr(3'd2, 16'h0606); wr(3'd1, 16'h0013);
    wr(3'd2, 16'h0603);
    wr(3'd3, 16'h0001);

    // R1 R2 R3 R4: table walk
    foreach (VEC[i]) sw_conv("R1/R3/R4 scan order", VEC[i][21:18], VEC[i][17:12], VEC[i][11:0]);
    chk(status_o == 16'h0201 && !irq_o, "R6 half status, R9 irq disabled", 32'(status_o), 32'h0201);
    foreach (VEC[i]) pop_chk("R2 tagged word", {VEC[i][21:18], VEC[i][11:0]});
    chk(status_o == 16'h0101, "R6 empty after drain", 32'(status_o), 32'h0101);

    // R6: control echo
    wr(3'd3, 16'h005A);
    chk(status_o == 16'h015A, "R6 control echo", 32'(status_o), 32'h015A);

    // R5: trigger sources, single channel 7
    wr(3'd2, 16'h0707);
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'h0);
    no_start("R5 sw trigger disabled");
    chk(status_o == 16'h0100, "R5 nothing stored", 32'(status_o), 32'h0100);
    wr(3'd3, 16'h0002);
    @(negedge clk_i); pacer_tick_i = 1'b1; @(negedge clk_i); pacer_tick_i = 1'b0;
    wait_start("R5 pacer", 4'd7, 6'h00); done(12'h101, 1'b0, 1'b0);
    wr(3'd3, 16'h000A);
    @(negedge clk_i); pacer_tick_i = 1'b1; @(negedge clk_i); pacer_tick_i = 1'b0;
    no_start("R5 gated pacer blocked");
    ext_gate_i = 1'b1;
    @(negedge clk_i); pacer_tick_i = 1'b1; @(negedge clk_i); pacer_tick_i = 1'b0;
    wait_start("R5 gated pacer open", 4'd7, 6'h00); done(12'h102, 1'b0, 1'b0);
    ext_gate_i = 1'b0;
    wr(3'd3, 16'h0004);
    @(negedge clk_i); ext_trig_i = 1'b1; @(negedge clk_i);
    wait_start("R5 ext edge", 4'd7, 6'h00); done(12'h103, 1'b0, 1'b0);
    no_start("R5 ext level held");
    ext_trig_i = 1'b0;

    // R8: clear empties
    wr(3'd5, 16'h0);
    chk(status_o == 16'h0104, "R8 clear fifo", 32'(status_o), 32'h0104);

    // R13: trigger while busy dropped
    wr(3'd3, 16'h0001);
    wr(3'd0, 16'h0);
    wait_start("R13 first", 4'd7, 6'h00);
    wr(3'd0, 16'h0);
    done(12'h0AA, 1'b0, 1'b0);
    no_start("R13 second trigger dropped");
    pop_chk("R13 one word", 16'h70AA);
    chk(status_o[8], "R13 only one stored", 32'(status_o), 32'h0101);

    // R1 wrap through 15/0; R3 differential next to last
    wr(3'd2, 16'h010E);
    sw_conv("R1 wrap 14", 4'd14, 6'h00, 12'h1);
    sw_conv("R1 wrap 15", 4'd15, 6'h00, 12'h2);
    sw_conv("R1 wrap 0",  4'd0,  6'h00, 12'h3);
    sw_conv("R1 wrap 1",  4'd1,  6'h00, 12'h4);
    sw_conv("R1 back 14", 4'd14, 6'h00, 12'h5);
    wr(3'd2, 16'h0808); wr(3'd1, 16'h0020);
    wr(3'd2, 16'h0908);
    sw_conv("R3 diff before last", 4'd8, 6'h20, 12'h6);
    sw_conv("R3 diff returns first", 4'd8, 6'h20, 12'h7);
    wr(3'd5, 16'h0);

    // R9 R12: every-sample interrupt
    wr(3'd2, 16'h0707);
    wr(3'd3, 16'h0011);
    sw_conv("R9 irq set", 4'd7, 6'h00, 12'h010);
    chk(irq_o, "R9 irq after store", 32'(irq_o), 32'd1);
    wr(3'd4, 16'h0);
    chk(!irq_o, "R9 irq clear", 32'(irq_o), 32'd0);
    wr(3'd0, 16'h0);
    wait_start("R12 conv", 4'd7, 6'h00);
    done(12'h011, 1'b0, 1'b1);
    chk(irq_o, "R12 store beats clear", 32'(irq_o), 32'd1);
    wr(3'd5, 16'h0); wr(3'd4, 16'h0);

    // R11: pop and store together
    wr(3'd3, 16'h0001);
    sw_conv("R11 first", 4'd7, 6'h00, 12'h111);
    wr(3'd0, 16'h0);
    wait_start("R11 second", 4'd7, 6'h00);
    done(12'h222, 1'b1, 1'b0);
    chk(fifo_data_o == 16'h7222 && !status_o[8], "R11 head after pop+store", 32'(fifo_data_o), 32'h7222);
    pop_chk("R11 last word", 16'h7222);
    chk(status_o[8], "R11 empty", 32'(status_o), 32'h0101);

    // R10: half-full interrupt
    wr(3'd3, 16'h0031);
    for (int i = 0; i < 7; i++) sw_conv("R10 fill", 4'd7, 6'h00, 12'(i));
    chk(!irq_o, "R10 no irq below half", 32'(irq_o), 32'd0);
    sw_conv("R10 fill", 4'd7, 6'h00, 12'd7);
    chk(irq_o, "R10 irq at half", 32'(irq_o), 32'd1);

    // R7: full, discard, sticky
    for (int i = 8; i < DEPTH; i++) sw_conv("R7 fill", 4'd7, 6'h00, 12'(i));
    chk(status_o == 16'h0E31, "R7 full status", 32'(status_o), 32'h0E31);
    sw_conv("R7 overrun conv", 4'd7, 6'h00, 12'hABC);
    for (int i = 0; i < DEPTH; i++) pop_chk("R7 word kept", {4'd7, 12'(i)});
    chk(status_o == 16'h0D31, "R7 full sticky, new result dropped", 32'(status_o), 32'h0D31);
    wr(3'd5, 16'h0);
    chk(status_o == 16'h0931, "R8 clear drops full", 32'(status_o), 32'h0931);
    wr(3'd4, 16'h0);
    chk(status_o == 16'h0131, "R9 clear int", 32'(status_o), 32'h0131);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule